// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror and Gate

This block holds the per-channel interrupt status flags of a two-channel disk controller. Each flag appears in two places in configuration space. The channel 0 flag sits in one status byte and the channel 1 flag in another. A shared mode byte holds both flags again, next to two per-channel block bits. The block keeps every copy of a flag in agreement. It applies write-one-to-clear semantics to configuration writes. It combines the unblocked flags into a single level-sensitive PCI interrupt line.

A flag is set or cleared only when the drive interrupt level of its channel changes: the flag then takes the new level. Software can clear a flag by writing a one to any of its copies. It can never set a flag. The block bits are loaded only through a separate byte port. A write, a level change or a block update is fully resolved in the clock edge that takes it. No copy is ever seen out of step with another.

Top module: `imx_irq_mirror`

## Requirements
- R1: After reset all three status bytes read 0x00, the interrupt line is low and the interrupt pin byte reads 0x01 (pin A).
- R2: A rising drive level on channel 0 sets bit 2 of byte 0x50 and bit 2 of byte 0x71. A rising drive level on channel 1 sets bit 4 of byte 0x57 and bit 3 of byte 0x71. Both copies change at the first clock edge after the level change.
- R3: Configuration writes never set a flag. All bits of bytes 0x50 and 0x57 other than the flag bits read zero.
- R4: Writing a one to bit 2 of byte 0x50 clears the channel 0 flag in both of its copies. Writing a one to bit 4 of byte 0x57 clears the channel 1 flag in both of its copies. Writing a zero leaves the flag unchanged.
- R5: Writing ones to bits 2 and 3 of byte 0x71 clears the corresponding flags there and also in bytes 0x50 and 0x57.
- R6: Configuration writes use a dword byte address (bits 1:0 ignored) and four byte enables; lane n carries byte address+n in data bits 8n+7:8n. A byte whose enable is low is not affected.
- R7: A falling drive level clears the channel's flag in all copies. A flag cleared by software stays clear while the drive level stays high.
- R8: The interrupt line equals (flag0 AND NOT block0) OR (flag1 AND NOT block1). It is updated in the same cycle as the flags.
- R9: A write on the block port loads bits 5:4 of its data into bits 5:4 of byte 0x71 (block1, block0). Configuration writes never change the block bits.
- R10: If a drive level change and a configuration clear hit the same flag in the same cycle, the level change wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_irq | input | 2 | Drive interrupt level per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (dword aligned) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| blk_we | input | 1 | Block-bit write strobe |
| blk_wdata | input | 8 | Block-bit write data (bits 5:4 used) |
| stat0_byte | output | 8 | Contents of byte 0x50 |
| stat1_byte | output | 8 | Contents of byte 0x57 |
| mode_byte | output | 8 | Contents of byte 0x71 |
| irq_pin_byte | output | 8 | Interrupt pin byte, constant 0x01 |
| irq_out | output | 1 | PCI interrupt level |

## Verification
The bench clears a flag through each of its aliases and checks the other copy in the same sample. A design that copied in the wrong direction, or only one way, would leave a stale flag in one byte. It writes all ones into the flag bytes to catch a design that lets a write set a flag or change a block bit. It also leaves a drive level high after a software clear, which exposes a design that tracks the level instead of its edges. A write with its byte enable low and a same-cycle clash between a level edge and a clear check lane decoding and update order. Walking the block bits while both flags are set shows whether each channel is gated by its own block bit.

// File: rtl/imx_pkg.sv
package imx_pkg;
  localparam int NCH       = 2;
  localparam int OFS_STAT0 = 'h50;
  localparam int BIT_STAT0 = 2;
  localparam int OFS_STAT1 = 'h57;
  localparam int BIT_STAT1 = 4;
  localparam int OFS_MODE  = 'h71;
  localparam int BIT_MFLAG = 2;
  localparam int BIT_MBLK  = 4;
  localparam logic [7:0] PIN_A = 8'h01;
endpackage

// File: rtl/imx_lvl_track.sv
module imx_lvl_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic chg_o
);
  logic prev_q;

  assign chg_o = lvl_i ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (chg_o) prev_q <= lvl_i;
  end
endmodule

// File: rtl/imx_mirror.sv
module imx_mirror
  import imx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW/8-1:0] cfg_be,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            blk_we,
  input  logic [7:0]      blk_wdata,
  input  logic [NCH-1:0]  lvl,
  input  logic [NCH-1:0]  lvl_chg,
  output logic            stat0_o,
  output logic            stat1_o,
  output logic [NCH-1:0]  flags_o,
  output logic [NCH-1:0]  blk_o
);
  localparam int LN0 = OFS_STAT0 % 4;
  localparam int LN1 = OFS_STAT1 % 4;
  localparam int LNM = OFS_MODE % 4;
  localparam logic [AW-3:0] DWA0 = (AW-2)'(OFS_STAT0 >> 2);
  localparam logic [AW-3:0] DWA1 = (AW-2)'(OFS_STAT1 >> 2);
  localparam logic [AW-3:0] DWAM = (AW-2)'(OFS_MODE >> 2);

  logic           s0_q, s1_q, s0_d, s1_d;
  logic [NCH-1:0] m_q, m_d, b_q, b_d;
  logic           hit0, hit1, hitm, upd;

  assign hit0 = cfg_we && (cfg_addr[AW-1:2] == DWA0) && cfg_be[LN0];
  assign hit1 = cfg_we && (cfg_addr[AW-1:2] == DWA1) && cfg_be[LN1];
  assign hitm = cfg_we && (cfg_addr[AW-1:2] == DWAM) && cfg_be[LNM];
  assign upd  = hit0 | hit1 | hitm | blk_we | (|lvl_chg);

  always_comb begin
    s0_d = s0_q;
    s1_d = s1_q;
    m_d  = m_q;
    b_d  = b_q;
    // configuration write: clear, then resync in the direction of the byte hit
    if (hit0 && cfg_wdata[LN0*8+BIT_STAT0]) s0_d = 1'b0;
    if (hit1 && cfg_wdata[LN1*8+BIT_STAT1]) s1_d = 1'b0;
    if (hitm) m_d = m_d & ~cfg_wdata[LNM*8+BIT_MFLAG +: NCH];
    if (hit0 || hit1) m_d = {s1_d, s0_d};
    if (hitm) begin
      s0_d = m_d[0];
      s1_d = m_d[1];
    end
    // block-bit port
    if (blk_we) begin
      b_d  = blk_wdata[BIT_MBLK +: NCH];
      s0_d = m_d[0];
      s1_d = m_d[1];
    end
    // drive level changes are applied last and win
    for (int c = 0; c < NCH; c++) begin
      if (lvl_chg[c]) m_d[c] = lvl[c];
    end
    if (|lvl_chg) begin
      s0_d = m_d[0];
      s1_d = m_d[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
      m_q  <= '0;
      b_q  <= '0;
    end else if (upd) begin
      s0_q <= s0_d;
      s1_q <= s1_d;
      m_q  <= m_d;
      b_q  <= b_d;
    end
  end

  assign stat0_o = s0_q;
  assign stat1_o = s1_q;
  assign flags_o = m_q;
  assign blk_o   = b_q;

  AST_ALIAS_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    s0_q == m_q[0]);  // R4
  AST_ALIAS_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_q == m_q[1]);  // R5
  AST_NO_SW_SET0: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_chg[0] |=> !$rose(m_q[0]));  // R3
  AST_NO_SW_SET1: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_chg[1] |=> !$rose(m_q[1]));  // R3
  AST_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_chg[0] |=> (m_q[0] == $past(lvl[0])));  // R10
  AST_BLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_we |=> $stable(b_q));  // R9
endmodule

// File: rtl/imx_irq_gate.sv
module imx_irq_gate
  import imx_pkg::*;
(
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] blk,
  output logic           irq
);
  assign irq = |(flags & ~blk);
endmodule

// File: rtl/imx_irq_mirror.sv
module imx_irq_mirror
  import imx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      drv_irq,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW/8-1:0] cfg_be,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            blk_we,
  input  logic [7:0]      blk_wdata,
  output logic [7:0]      stat0_byte,
  output logic [7:0]      stat1_byte,
  output logic [7:0]      mode_byte,
  output logic [7:0]      irq_pin_byte,
  output logic            irq_out
);
  logic [NCH-1:0] chg, flags, blk;
  logic           s0, s1;

  for (genvar c = 0; c < NCH; c++) begin : g_trk
    imx_lvl_track u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (drv_irq[c]),
      .chg_o (chg[c])
    );
  end

  imx_mirror #(.AW(AW), .DW(DW)) u_mir (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .blk_we    (blk_we),
    .blk_wdata (blk_wdata),
    .lvl       (drv_irq),
    .lvl_chg   (chg),
    .stat0_o   (s0),
    .stat1_o   (s1),
    .flags_o   (flags),
    .blk_o     (blk)
  );

  imx_irq_gate u_gate (
    .flags (flags),
    .blk   (blk),
    .irq   (irq_out)
  );

  always_comb begin
    stat0_byte = '0;
    stat1_byte = '0;
    mode_byte  = '0;
    stat0_byte[BIT_STAT0]            = s0;
    stat1_byte[BIT_STAT1]            = s1;
    mode_byte[BIT_MFLAG +: NCH]      = flags;
    mode_byte[BIT_MBLK +: NCH]       = blk;
  end

  assign irq_pin_byte = PIN_A;

  AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&blk) |-> !irq_out);  // R8
  AST_UNBLOCKED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !blk[0]) |-> irq_out);  // R8
endmodule

// File: tb/imx_irq_mirror_bench.sv
module imx_irq_mirror_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  drv_irq = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        blk_we = 1'b0;
  logic [7:0]  blk_wdata = '0;
  logic [7:0]  stat0_byte, stat1_byte, mode_byte, irq_pin_byte;
  logic        irq_out;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  imx_irq_mirror u_imx_irq_mirror (
    .clk, .rst_n, .drv_irq, .cfg_we, .cfg_addr, .cfg_be, .cfg_wdata,
    .blk_we, .blk_wdata, .stat0_byte, .stat1_byte, .mode_byte,
    .irq_pin_byte, .irq_out
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic state(input string req, input logic [7:0] s0, input logic [7:0] s1,
                       input logic [7:0] m, input logic irq);
    chk(req, stat0_byte, s0);
    chk(req, stat1_byte, s1);
    chk(req, mode_byte, m);
    chk(req, {7'd0, irq_out}, {7'd0, irq});
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic blk_wr(input logic [7:0] d);
    @(negedge clk);
    blk_we = 1'b1; blk_wdata = d;
    @(negedge clk);
    blk_we = 1'b0;
  endtask

  task automatic set_lvl(input int ch, input logic v);
    @(negedge clk);
    drv_irq[ch] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    state("R1", 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R1", irq_pin_byte, 8'h01);
  endtask

  task automatic t_level_set;
    set_lvl(0, 1'b1);
    state("R2", 8'h04, 8'h00, 8'h04, 1'b1);
    set_lvl(1, 1'b1);
    state("R2", 8'h04, 8'h10, 8'h0C, 1'b1);
  endtask

  task automatic t_alias_clear;
    cfg_wr(8'h50, 4'b0001, 32'h0000_0000);
    state("R4", 8'h04, 8'h10, 8'h0C, 1'b1);
    cfg_wr(8'h50, 4'b0001, 32'h0000_0004);
    state("R4", 8'h00, 8'h10, 8'h08, 1'b1);
    cfg_wr(8'h54, 4'b1000, 32'h1000_0000);
    state("R4", 8'h00, 8'h00, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    state("R7", 8'h00, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_no_set;
    cfg_wr(8'h50, 4'b1111, 32'hFFFF_FFFF);
    state("R3", 8'h00, 8'h00, 8'h00, 1'b0);
    cfg_wr(8'h54, 4'b1111, 32'hFFFF_FFFF);
    state("R3", 8'h00, 8'h00, 8'h00, 1'b0);
    cfg_wr(8'h70, 4'b1111, 32'hFFFF_FFFF);
    state("R9", 8'h00, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_mode_clear;
    set_lvl(0, 1'b0);
    set_lvl(0, 1'b1);
    state("R2", 8'h04, 8'h00, 8'h04, 1'b1);
    cfg_wr(8'h70, 4'b0000, 32'h0000_0400);
    state("R6", 8'h04, 8'h00, 8'h04, 1'b1);
    cfg_wr(8'h70, 4'b1101, 32'h0000_0400);
    state("R6", 8'h04, 8'h00, 8'h04, 1'b1);
    cfg_wr(8'h70, 4'b0010, 32'h0000_0400);
    state("R5", 8'h00, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_gate;
    set_lvl(0, 1'b0);
    set_lvl(0, 1'b1);
    state("R8", 8'h04, 8'h00, 8'h04, 1'b1);
    blk_wr(8'h10);
    state("R8", 8'h04, 8'h00, 8'h14, 1'b0);
    blk_wr(8'hFF);
    state("R9", 8'h04, 8'h00, 8'h34, 1'b0);
    set_lvl(1, 1'b0);
    set_lvl(1, 1'b1);
    state("R8", 8'h04, 8'h10, 8'h3C, 1'b0);
    blk_wr(8'h20);
    state("R8", 8'h04, 8'h10, 8'h2C, 1'b1);
    blk_wr(8'h00);
    state("R9", 8'h04, 8'h10, 8'h0C, 1'b1);
  endtask

  task automatic t_fall;
    set_lvl(0, 1'b0);
    state("R7", 8'h00, 8'h10, 8'h08, 1'b1);
    set_lvl(1, 1'b0);
    state("R7", 8'h00, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    drv_irq[0] = 1'b1;
    cfg_we = 1'b1; cfg_addr = 8'h50; cfg_be = 4'b0001; cfg_wdata = 32'h0000_0004;
    @(negedge clk);
    cfg_we = 1'b0;
    state("R10", 8'h04, 8'h00, 8'h04, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level_set();
    t_alias_clear();
    t_no_set();
    t_mode_clear();
    t_gate();
    t_fall();
    t_collision();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule